// File: doc/BRIEF.md
# Guard-Gated Oscillator Phase Accumulator

This block keeps the phase word of the numerically controlled oscillator that drives a carrier derotator. On each sample of the useful part of an OFDM symbol it adds the active frequency word to the phase, wrapping modulo 2^W. During guard-interval samples the adder is idle and the phase register holds, which saves switching power. On the first useful sample after a guard interval it makes one jump. The jump equals the phase the idle guard samples would have added, so the phase stays continuous.

The guard interval is always a power-of-two number of samples. The jump is therefore the frequency word that was active during the guard interval, shifted left by the log2 length code and truncated to W bits. No multiplier is needed. A new frequency word is accepted once per symbol, together with the symbol-start pulse. That pulse comes with the first useful sample, and the new word already drives that sample. The word that drives the jump is the one held before the new word replaces it. Sine and cosine generation are left to the logic downstream.

Top module: `gi_phase_acc`

## Requirements
- R1: After reset, phase_o is 0 and no guard jump is pending.
- R2: A strobe with gi_i=0 and sym_start_i=0 adds the held frequency word to phase_o, visible on the next cycle.
- R3: A strobe with gi_i=1 leaves phase_o unchanged.
- R4: A cycle without a strobe leaves phase_o unchanged.
- R5: The first useful strobe after one or more guard strobes also adds (held word << gi_log2_i), truncated to W bits. A useful strobe with no preceding guard strobes adds no jump.
- R6: On a useful strobe with sym_start_i=1, freq_i is added for that sample and is held for the samples that follow. The guard jump on the same strobe uses the word held before it.
- R7: All additions wrap modulo 2^W.
- R8: After every useful strobe, phase_o equals the value of a reference accumulator that added the active word on every strobe, guard samples included. The active word is freq_i on a symbol-start strobe and the held word otherwise.
- R9: Every code 0..MAX_LOG2 on gi_log2_i selects a guard length of 2^code samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Sample strobe |
| gi_i | input | 1 | Current sample lies in the guard interval |
| sym_start_i | input | 1 | First useful sample of a symbol; loads freq_i |
| freq_i | input | W | Per-sample phase increment for the new symbol |
| gi_log2_i | input | $clog2(MAX_LOG2+1) | log2 of the guard length in samples |
| phase_o | output | W | Accumulated phase |

## Verification
The assertions assume a fixed input discipline. Each run of guard strobes contains exactly 2^gi_log2_i samples and ends at a useful strobe that carries sym_start_i. The code stays within 0..MAX_LOG2, and sym_start_i is raised only on a useful strobe. The stimulus meets these assumptions by building each symbol from a counted guard run of exactly 2^code samples followed by a useful run that opens with the start pulse. Idle cycles are placed inside both runs. The stimulus sweeps every length code with several frequency words, including words that force wrap-around, and adds one leading useful run that has no guard before it.

// File: rtl/gi_phase_pkg.sv
package gi_phase_pkg;
  localparam int unsigned DEF_W        = 24;
  localparam int unsigned DEF_MAX_LOG2 = 11;

  typedef enum logic [1:0] {
    SMP_NONE = 2'd0,
    SMP_GI   = 2'd1,
    SMP_USE  = 2'd2
  } smp_kind_e;

  function automatic smp_kind_e classify(input logic vld, input logic gi);
    if (!vld)   return SMP_NONE;
    else if (gi) return SMP_GI;
    else        return SMP_USE;
  endfunction
endpackage

// File: rtl/gi_tracker.sv
module gi_tracker
  import gi_phase_pkg::*;
#(
  parameter int unsigned W        = DEF_W,
  parameter int unsigned MAX_LOG2 = DEF_MAX_LOG2,
  localparam int unsigned CODE_W  = $clog2(MAX_LOG2 + 1),
  localparam int unsigned CNT_W   = MAX_LOG2 + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  smp_kind_e         kind_i,
  input  logic              sym_start_i,
  input  logic [W-1:0]      freq_i,
  input  logic [CODE_W-1:0] gi_log2_i,
  output logic [W-1:0]      freq_held_o,
  output logic [W-1:0]      freq_act_o,
  output logic              pend_o
);
  logic [W-1:0]     freq_q;
  logic             pend_q;
  logic [CNT_W-1:0] gi_cnt_q;
  logic [CNT_W-1:0] gi_len;

  assign gi_len = {{(CNT_W-1){1'b0}}, 1'b1} << gi_log2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q   <= '0;
      pend_q   <= 1'b0;
      gi_cnt_q <= '0;
    end else begin
      case (kind_i)
        SMP_GI: begin
          pend_q   <= 1'b1;
          gi_cnt_q <= gi_cnt_q + 1'b1;
        end
        SMP_USE: begin
          pend_q   <= 1'b0;
          gi_cnt_q <= '0;
          if (sym_start_i) freq_q <= freq_i;
        end
        default: ;
      endcase
    end
  end

  assign freq_held_o = freq_q;
  assign freq_act_o  = (kind_i == SMP_USE && sym_start_i) ? freq_i : freq_q;
  assign pend_o      = pend_q;

  AST_GI_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == SMP_USE && pend_q) |-> (gi_cnt_q == gi_len)) else $error("gi run length"); // R9
  AST_GI_ENDS_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == SMP_USE && pend_q) |-> sym_start_i) else $error("gi not closed by start"); // R6
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i != SMP_NONE) |-> (gi_log2_i <= CODE_W'(MAX_LOG2))) else $error("code range"); // R9
  AST_START_USEFUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_i |-> (kind_i == SMP_USE)) else $error("start outside useful"); // R6
endmodule

// File: rtl/gi_predictor.sv
module gi_predictor #(
  parameter int unsigned W        = 24,
  parameter int unsigned MAX_LOG2 = 11,
  localparam int unsigned CODE_W  = $clog2(MAX_LOG2 + 1)
) (
  input  logic [W-1:0]      freq_i,
  input  logic [CODE_W-1:0] gi_log2_i,
  input  logic              pend_i,
  output logic [W-1:0]      jump_o
);
  logic [W-1:0] cand [MAX_LOG2+1];

  for (genvar k = 0; k <= MAX_LOG2; k++) begin : g_shift
    if (k < W) begin : g_in
      assign cand[k] = freq_i << k;
    end else begin : g_out
      assign cand[k] = '0;
    end
  end

  always_comb begin
    jump_o = '0;
    if (pend_i) begin
      for (int k = 0; k <= MAX_LOG2; k++) begin
        if (gi_log2_i == CODE_W'(k)) jump_o = cand[k];
      end
    end
  end
endmodule

// File: rtl/phase_reg.sv
module phase_reg
  import gi_phase_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  smp_kind_e    kind_i,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] jump_i,
  output logic [W-1:0] phase_o
);
  logic [W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (kind_i == SMP_USE) phase_q <= phase_q + step_i + jump_i;
  end

  assign phase_o = phase_q;

  AST_GI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == SMP_GI) |=> $stable(phase_q)) else $error("gi moved phase"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == SMP_NONE) |=> $stable(phase_q)) else $error("idle moved phase"); // R4
endmodule

// File: rtl/gi_phase_acc.sv
module gi_phase_acc
  import gi_phase_pkg::*;
#(
  parameter int unsigned W        = DEF_W,
  parameter int unsigned MAX_LOG2 = DEF_MAX_LOG2,
  localparam int unsigned CODE_W  = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic              gi_i,
  input  logic              sym_start_i,
  input  logic [W-1:0]      freq_i,
  input  logic [CODE_W-1:0] gi_log2_i,
  output logic [W-1:0]      phase_o
);
  smp_kind_e    kind;
  logic [W-1:0] freq_held, freq_act, jump;
  logic         pend;

  assign kind = classify(smp_vld_i, gi_i);

  gi_tracker #(.W(W), .MAX_LOG2(MAX_LOG2)) u_trk (
    .clk_i, .rst_ni, .kind_i(kind), .sym_start_i, .freq_i, .gi_log2_i,
    .freq_held_o(freq_held), .freq_act_o(freq_act), .pend_o(pend)
  );

  gi_predictor #(.W(W), .MAX_LOG2(MAX_LOG2)) u_pred (
    .freq_i(freq_held), .gi_log2_i, .pend_i(pend), .jump_o(jump)
  );

  phase_reg #(.W(W)) u_ph (
    .clk_i, .rst_ni, .kind_i(kind), .step_i(freq_act), .jump_i(jump), .phase_o
  );

  AST_NO_JUMP_COLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == SMP_USE && !pend) |=> (phase_o == $past(phase_o) + $past(freq_act))) else $error("jump without gi"); // R5
endmodule

// File: tb/gi_phase_acc_tb.sv
module gi_phase_acc_tb;
  localparam int W = 24;
  localparam int MAXL = 11;
  localparam int CW = $clog2(MAXL + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 0, gi = 0, st = 0;
  logic [W-1:0] freq = '0;
  logic [CW-1:0] code = '0;
  logic [W-1:0] phase;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] ref_ph = '0, act = '0, hold;

  always #5 clk = ~clk;

  gi_phase_acc #(.W(W), .MAX_LOG2(MAXL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .gi_i(gi),
    .sym_start_i(st), .freq_i(freq), .gi_log2_i(code), .phase_o(phase)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); vld = 0; gi = 0; st = 0;
    hold = phase;
    @(posedge clk); #1;
    chk("R4 idle hold", phase, hold);
  endtask

  task automatic gi_smp();
    @(negedge clk); vld = 1; gi = 1; st = 0;
    hold = phase;
    @(posedge clk); #1; vld = 0;
    ref_ph = ref_ph + act;
    chk("R3 gi hold", phase, hold);
  endtask

  task automatic use_smp(input bit start, input logic [W-1:0] f, input bit after_gi);
    logic [W:0] sum;
    @(negedge clk); vld = 1; gi = 0; st = start; freq = f;
    @(posedge clk); #1; vld = 0; st = 0;
    if (start) act = f;
    sum = {1'b0, ref_ph} + {1'b0, act};
    ref_ph = sum[W-1:0];
    if (after_gi) chk($sformatf("R5 R6 R9 jump code=%0d", code), phase, ref_ph);
    else if (sum[W]) chk("R7 wrap", phase, ref_ph);
    else chk("R2 R8 step", phase, ref_ph);
  endtask

  initial begin
    logic [W-1:0] fw;
    #23; rst_n = 1'b1; #1;
    chk("R1 reset phase", phase, '0);
    // leading useful run, no guard before it
    use_smp(1, 24'h012345, 0);
    for (int i = 0; i < 5; i++) use_smp(0, 24'h0, 0);
    idle();
    for (int c = 0; c <= MAXL; c++) begin
      for (int p = 0; p < 3; p++) begin
        code = CW'(c);
        fw = (p == 0) ? 24'(24'h000731 * (c + 1)) : (p == 1) ? 24'hFFF3A1 : 24'h7FFFFF - 24'(c);
        for (int g = 0; g < (1 << c); g++) begin
          gi_smp();
          if (g == 1) idle();
        end
        use_smp(1, fw, 1);
        for (int u = 0; u < 6; u++) begin
          use_smp(0, 24'h0, 0);
          if (u == 2) idle();
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule